// File: doc/BRIEF.md
# Host Local Bus Slave with Ready Handshake

This block lets an external host, running asynchronously to the chip, write into the chip over a 16-bit local bus. The bus has one shared direction line, two active-low selects and an active-low ready line that the slave pulses to end every access. One select reaches a single page configuration register held inside the block. The other select reaches a memory window through a request/acknowledge port towards the internal fabric. The memory behind that port is not part of this block.

The selects and the direction line pass through two-flop synchronizers into a 100 MHz clock domain. Once exactly one select is seen, the block captures the address, segment and byte enables. After a settle delay it captures the write data. A configuration write updates the enabled byte lanes of the page register. A memory access raises a request and waits for the acknowledge. Ready is then driven low for exactly two clock cycles. It stays driven high until the host releases the select.

A write is followed by a three-cycle recovery window in which a new select is not acted on. If both selects are seen together, the block raises a conflict flag. Read data return is outside the block: a read only turns on the data-drive enable and completes the handshake.

Top module: `hostbus_slave`

## Requirements
- R1: While reset is held, the block shows an idle bus. `lb_rdy_n` is 1, `lb_rdy_oe`, `lb_data_oe`, `mem_req` and `sel_conflict` are 0, and `page_cfg` is 0.
- R2: Take a page write (`lb_cs_page_n` low, `lb_wr_n` low). Ready goes low after the fifth rising edge that samples the select low, and stays low for exactly two cycles. On the edge where ready falls, every byte lane whose enable is low is written from `lb_wdata`: enable bit 0 covers bits 7:0 and enable bit 1 covers bits 15:8. Other lanes keep their value.
- R3: Take a memory access (`lb_cs_mem_n` low). `mem_req` rises after the fifth rising edge that samples the select low. It stays high until the acknowledge is sampled. During that time it carries the address, the segment, the byte enables as active-high `mem_be`, the data, and `mem_we` = 1 for a write. Ready stays high until the edge that samples `mem_ack`, then goes low for exactly two cycles.
- R4: `lb_rdy_oe` is 1 from the detection of a select until its release is detected, and 0 otherwise. Whenever `lb_rdy_oe` is 0, `lb_rdy_n` is 1. After the ready pulse, ready stays 1 until the select is released.
- R5: After a write access, a new select is not acted on for three cycles after the release is detected. Suppose the select is reasserted one cycle after release. Its ready then falls 8 cycles after assertion following a write, and 5 cycles following a read.
- R6: An access that starts with `lb_wr_n` high is a read. `lb_data_oe` is high for as long as `lb_rdy_oe` is. A page read leaves `page_cfg` unchanged. A memory read issues `mem_req` with `mem_we` = 0.
- R7: `sel_conflict` is 1 in the cycle after both synchronized selects are active, and 0 otherwise. If both selects arrive together while idle, no access starts and ready is never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lb_cs_page_n | input | 1 | Select for the page configuration register, active low |
| lb_cs_mem_n | input | 1 | Select for the memory window, active low |
| lb_wr_n | input | 1 | Shared direction line, 0 = write |
| lb_addr | input | 21 | Host address |
| lb_seg | input | 2 | Host segment |
| lb_be_n | input | 2 | Byte enables, active low |
| lb_wdata | input | 16 | Host write data |
| lb_rdy_n | output | 1 | Ready, active low |
| lb_rdy_oe | output | 1 | Drive enable for the ready line |
| lb_data_oe | output | 1 | Drive enable for the data bus during reads |
| page_cfg | output | 16 | Page configuration register |
| mem_req | output | 1 | Memory window request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 21 | Captured address |
| mem_seg | output | 2 | Captured segment |
| mem_be | output | 2 | Captured byte enables, active high |
| mem_wdata | output | 16 | Captured write data |
| mem_ack | input | 1 | Memory window acknowledge |
| sel_conflict | output | 1 | Both selects active |

## Verification
The hardest case to reach from the pins is a select that returns while the recovery window is still open. The bench produces it by releasing a select and reasserting it on the very next cycle, once after a write and once after a read, and compares the two ready delays. A second select arriving during an access is produced by asserting the memory select while a page access sits in its hold phase. A behavioural model in the bench tracks every output on every cycle alongside these directed checks.

// File: rtl/hbs_pkg.sv
// Shared types for the host local bus slave.
package hbs_pkg;
    // Access sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_MEM,
        ST_READY,
        ST_HOLD,
        ST_RECOVER
    } hbs_state_t;
endpackage

// File: rtl/hbs_sync.sv
// Two-flop synchronizer for a group of asynchronous control lines.
// Assumes each bit is an independent level; no bus coherence implied.
module hbs_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages towards the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hbs_ctrl.sv
// Access sequencer: detects a single active select, waits for data to settle,
// runs the memory handshake, times the ready pulse and the recovery window.
// Assumes synchronized, active-high select and write inputs.
module hbs_ctrl
    import hbs_pkg::*;
#(
    parameter int SETTLE_CYC  = 2,
    parameter int READY_CYC   = 2,
    parameter int RECOVER_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_page,
    input  logic sel_mem,
    input  logic wr,
    input  logic mem_ack,
    output logic start,
    output logic latch,
    output logic page_we,
    output logic mem_req,
    output logic is_write,
    output logic rdy_n,
    output logic rdy_oe,
    output logic data_oe,
    output logic conflict
);
    localparam int MAXC  = (SETTLE_CYC > READY_CYC) ?
                           ((SETTLE_CYC > RECOVER_CYC) ? SETTLE_CYC : RECOVER_CYC) :
                           ((READY_CYC > RECOVER_CYC) ? READY_CYC : RECOVER_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    hbs_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             kind_mem;
    logic             own_sel;

    assign own_sel = kind_mem ? sel_mem : sel_page;
    assign start   = (state == ST_IDLE) && (sel_page ^ sel_mem);
    assign latch   = (state == ST_SETTLE) && (cnt == CNT_W'(SETTLE_CYC - 1));
    assign page_we = latch && !kind_mem && is_write;
    assign mem_req = (state == ST_MEM);
    assign rdy_n   = (state != ST_READY);
    assign rdy_oe  = (state == ST_SETTLE) || (state == ST_MEM) ||
                     (state == ST_READY)  || (state == ST_HOLD);
    assign data_oe = rdy_oe && !is_write;

    // Sequencer state, phase counter and per-access attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            kind_mem <= 1'b0;
            is_write <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state    <= ST_SETTLE;
                    cnt      <= '0;
                    kind_mem <= sel_mem;
                    is_write <= wr;
                end
                ST_SETTLE: if (latch) begin
                    cnt   <= '0;
                    state <= kind_mem ? ST_MEM : ST_READY;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_MEM: if (mem_ack) begin
                    cnt   <= '0;
                    state <= ST_READY;
                end
                ST_READY: if (cnt == CNT_W'(READY_CYC - 1)) begin
                    cnt   <= '0;
                    state <= ST_HOLD;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                ST_HOLD: if (!own_sel) begin
                    cnt   <= '0;
                    state <= is_write ? ST_RECOVER : ST_IDLE;
                end
                ST_RECOVER: if (cnt == CNT_W'(RECOVER_CYC - 1)) begin
                    cnt   <= '0;
                    state <= ST_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Registered flag for two selects seen at once.
    always_ff @(posedge clk) begin
        if (!rst_n) conflict <= 1'b0;
        else        conflict <= sel_page & sel_mem;
    end

    a_r2_pulse_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |=> !rdy_n);
    a_r2_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && $past(!rdy_n)) |=> rdy_n);
    a_r3_req_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);
    a_r3_no_early_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> rdy_n);
    a_r4_quiet_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_oe |-> rdy_n);
    a_r6_oe_inside: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> rdy_oe);
    a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_page && sel_mem) |=> conflict);
endmodule

// File: rtl/hbs_datapath.sv
// Captures address, segment and byte enables at select detection, data after
// the settle delay, and holds the page register with per-lane write enables.
// Assumes bus fields are stable whenever start or latch is high.
module hbs_datapath #(
    parameter int ADDR_W = 21,
    parameter int SEG_W  = 2,
    parameter int LANES  = 2,
    localparam int DATA_W = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              latch,
    input  logic              page_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SEG_W-1:0]  bus_seg,
    input  logic [LANES-1:0]  bus_be_n,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] page,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [SEG_W-1:0]  cap_seg,
    output logic [LANES-1:0]  cap_be,
    output logic [DATA_W-1:0] cap_wdata
);
    // Address-phase capture at select detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_seg  <= '0;
            cap_be   <= '0;
        end else if (start) begin
            cap_addr <= bus_addr;
            cap_seg  <= bus_seg;
            cap_be   <= ~bus_be_n;
        end
    end

    // Data capture once the settle delay has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n)     cap_wdata <= '0;
        else if (latch) cap_wdata <= bus_wdata;
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        // Page register byte lane, written only when its enable was active.
        always_ff @(posedge clk) begin
            if (!rst_n)                    page[b*8 +: 8] <= 8'h00;
            else if (page_we && cap_be[b]) page[b*8 +: 8] <= bus_wdata[b*8 +: 8];
        end
    end
endmodule

// File: rtl/hostbus_slave.sv
// Host local bus slave: synchronizes the strobes, sequences one access at a
// time and exposes the page register and the memory window request port.
// Assumes address and byte enables valid at select assertion and held.
module hostbus_slave #(
    parameter int ADDR_W      = 21,
    parameter int SEG_W       = 2,
    parameter int LANES       = 2,
    parameter int SETTLE_CYC  = 2,
    parameter int READY_CYC   = 2,
    parameter int RECOVER_CYC = 3,
    localparam int DATA_W     = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lb_cs_page_n,
    input  logic              lb_cs_mem_n,
    input  logic              lb_wr_n,
    input  logic [ADDR_W-1:0] lb_addr,
    input  logic [SEG_W-1:0]  lb_seg,
    input  logic [LANES-1:0]  lb_be_n,
    input  logic [DATA_W-1:0] lb_wdata,
    output logic              lb_rdy_n,
    output logic              lb_rdy_oe,
    output logic              lb_data_oe,
    output logic [DATA_W-1:0] page_cfg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [SEG_W-1:0]  mem_seg,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    output logic              sel_conflict
);
    logic [2:0] sync_q;
    logic       start, latch, page_we;

    hbs_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lb_cs_page_n, lb_cs_mem_n, lb_wr_n}),
        .q     (sync_q)
    );

    hbs_ctrl #(
        .SETTLE_CYC  (SETTLE_CYC),
        .READY_CYC   (READY_CYC),
        .RECOVER_CYC (RECOVER_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_page (!sync_q[2]),
        .sel_mem  (!sync_q[1]),
        .wr       (!sync_q[0]),
        .mem_ack  (mem_ack),
        .start    (start),
        .latch    (latch),
        .page_we  (page_we),
        .mem_req  (mem_req),
        .is_write (mem_we),
        .rdy_n    (lb_rdy_n),
        .rdy_oe   (lb_rdy_oe),
        .data_oe  (lb_data_oe),
        .conflict (sel_conflict)
    );

    hbs_datapath #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .LANES(LANES)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .latch     (latch),
        .page_we   (page_we),
        .bus_addr  (lb_addr),
        .bus_seg   (lb_seg),
        .bus_be_n  (lb_be_n),
        .bus_wdata (lb_wdata),
        .page      (page_cfg),
        .cap_addr  (mem_addr),
        .cap_seg   (mem_seg),
        .cap_be    (mem_be),
        .cap_wdata (mem_wdata)
    );
endmodule

// File: tb/hostbus_slave_test.sv
// Bench: behavioural per-cycle model plus directed checks of latencies.
module hostbus_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_p_n = 1'b1, cs_m_n = 1'b1, wr_n = 1'b1;
    logic [20:0] addr = '0;
    logic [1:0]  seg = '0, be_n = 2'b11;
    logic [15:0] wdata = '0;
    logic        rdy_n, rdy_oe, data_oe, mreq, mwe, mack, confl;
    logic [15:0] page, mwd;
    logic [20:0] maddr;
    logic [1:0]  mseg, mbe;

    int checks = 0, fails = 0;
    int ack_lat = 0, acnt = 0;
    bit cmp_en = 0, done = 0;
    logic [20:0] x_addr; logic [1:0] x_seg, x_be; logic [15:0] x_data; logic x_we;

    always #5 clk = ~clk;

    hostbus_slave uut (
        .clk(clk), .rst_n(rst_n), .lb_cs_page_n(cs_p_n), .lb_cs_mem_n(cs_m_n),
        .lb_wr_n(wr_n), .lb_addr(addr), .lb_seg(seg), .lb_be_n(be_n),
        .lb_wdata(wdata), .lb_rdy_n(rdy_n), .lb_rdy_oe(rdy_oe),
        .lb_data_oe(data_oe), .page_cfg(page), .mem_req(mreq), .mem_we(mwe),
        .mem_addr(maddr), .mem_seg(mseg), .mem_be(mbe), .mem_wdata(mwd),
        .mem_ack(mack), .sel_conflict(confl)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural model: integer phases, delayed select samples.
    int p1, p2, m1, m2, w1, w2, mph, mc, mk, md, mcf;
    logic [15:0] mpage; logic [1:0] mlanes;
    always @(posedge clk) begin
        if (!rst_n) begin
            p1 = 0; p2 = 0; m1 = 0; m2 = 0; w1 = 0; w2 = 0;
            mph = 0; mc = 0; mk = 0; md = 0; mcf = 0; mpage = 16'h0;
        end else begin
            case (mph)
                0: if (p2 != m2) begin
                    mph = 1; mc = 0; mk = m2; md = w2; mlanes = ~be_n;
                end
                1: if (mc == 1) begin
                    if (!mk && md) begin
                        if (mlanes[0]) mpage[7:0] = wdata[7:0];
                        if (mlanes[1]) mpage[15:8] = wdata[15:8];
                    end
                    mph = mk ? 2 : 3; mc = 0;
                end else mc++;
                2: if (mack) begin mph = 3; mc = 0; end
                3: if (mc == 1) begin mph = 4; mc = 0; end else mc++;
                4: if ((mk ? m2 : p2) == 0) begin mph = md ? 5 : 0; mc = 0; end
                5: if (mc == 2) begin mph = 0; mc = 0; end else mc++;
                default: mph = 0;
            endcase
            mcf = p2 && m2;
            p2 = p1; m2 = m1; w2 = w1;
            p1 = !cs_p_n; m1 = !cs_m_n; w1 = !wr_n;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(rdy_n == (mph != 3), "R2", "ready level", rdy_n, (mph != 3));
            chk(rdy_oe == (mph >= 1 && mph <= 4), "R4", "ready drive", rdy_oe, (mph >= 1 && mph <= 4));
            chk(data_oe == (mph >= 1 && mph <= 4 && !md), "R6", "data drive", data_oe, (mph >= 1 && mph <= 4 && !md));
            chk(mreq == (mph == 2), "R3", "request level", mreq, (mph == 2));
            chk(page == mpage, "R2", "page register", page, mpage);
            chk(confl == mcf, "R7", "conflict flag", confl, mcf);
        end
    end

    // Memory acknowledge responder with field checks at acknowledge time.
    always @(negedge clk) begin
        if (!rst_n) begin
            mack <= 1'b0; acnt = 0;
        end else if (mreq && !mack) begin
            if (acnt >= ack_lat) begin
                mack <= 1'b1; acnt = 0;
                chk(maddr == x_addr, "R3", "mem address", maddr, x_addr);
                chk(mseg == x_seg, "R3", "mem segment", mseg, x_seg);
                chk(mbe == x_be, "R3", "mem byte enables", mbe, x_be);
                chk(mwd == x_data, "R3", "mem data", mwd, x_data);
                chk(mwe == x_we, "R6", "mem direction", mwe, x_we);
            end else acnt++;
        end else begin
            mack <= 1'b0;
        end
    end

    task automatic access(input bit to_mem, input bit is_wr, input logic [20:0] a,
                          input logic [1:0] s, input logic [1:0] ben,
                          input logic [15:0] d, output int lat, output int width);
        @(negedge clk);
        addr = a; seg = s; be_n = ben; wdata = d; wr_n = !is_wr;
        x_addr = a; x_seg = s; x_be = ~ben; x_data = d; x_we = is_wr;
        if (to_mem) cs_m_n = 1'b0; else cs_p_n = 1'b0;
        lat = 0; width = 0;
        while (rdy_n && lat < 60) begin @(negedge clk); lat++; end
        while (!rdy_n && width < 10) begin @(negedge clk); width++; end
        cs_p_n = 1'b1; cs_m_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R4", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat, wid;
        logic [15:0] snap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(rdy_n == 1'b1, "R1", "ready in reset", rdy_n, 1);
        chk(rdy_oe == 1'b0, "R1", "ready drive in reset", rdy_oe, 0);
        chk(data_oe == 1'b0, "R1", "data drive in reset", data_oe, 0);
        chk(mreq == 1'b0, "R1", "request in reset", mreq, 0);
        chk(confl == 1'b0, "R1", "conflict in reset", confl, 0);
        chk(page == 16'h0, "R1", "page in reset", page, 0);
        rst_n = 1'b1; cmp_en = 1;
        repeat (3) @(negedge clk);

        // R2: full-width page write, latency and width
        access(0, 1, 21'h1, 2'd0, 2'b00, 16'hA5C3, lat, wid);
        chk(lat == 5, "R2", "page write latency", lat, 5);
        chk(wid == 2, "R2", "page write ready width", wid, 2);
        repeat (6) @(negedge clk);
        chk(page == 16'hA5C3, "R2", "page both lanes", page, 16'hA5C3);
        // R2: low lane only
        access(0, 1, 21'h2, 2'd1, 2'b10, 16'h1234, lat, wid);
        repeat (6) @(negedge clk);
        chk(page == 16'hA534, "R2", "page low lane", page, 16'hA534);
        // R2: high lane only
        access(0, 1, 21'h3, 2'd2, 2'b01, 16'h99FF, lat, wid);
        repeat (6) @(negedge clk);
        chk(page == 16'h9934, "R2", "page high lane", page, 16'h9934);
        // R2: no lane enabled
        access(0, 1, 21'h4, 2'd3, 2'b11, 16'h0000, lat, wid);
        repeat (6) @(negedge clk);
        chk(page == 16'h9934, "R2", "page no lane", page, 16'h9934);

        // R3: memory write with slow acknowledge
        ack_lat = 3;
        access(1, 1, 21'h1ABCD, 2'd2, 2'b00, 16'hBEEF, lat, wid);
        chk(lat == 9, "R3", "mem write latency", lat, 9);
        chk(wid == 2, "R3", "mem ready width", wid, 2);
        repeat (6) @(negedge clk);
        // R3: immediate acknowledge, one lane
        ack_lat = 0;
        access(1, 1, 21'h00F0F, 2'd1, 2'b01, 16'h5A5A, lat, wid);
        chk(lat == 6, "R3", "mem fast latency", lat, 6);
        repeat (6) @(negedge clk);

        // R6: memory read and page read
        access(1, 0, 21'h12345, 2'd3, 2'b00, 16'h7777, lat, wid);
        repeat (6) @(negedge clk);
        snap = page;
        access(0, 0, 21'h5, 2'd0, 2'b00, 16'h0001, lat, wid);
        chk(lat == 5, "R6", "page read latency", lat, 5);
        repeat (6) @(negedge clk);
        chk(page == snap, "R6", "page unchanged by read", page, snap);

        // R5: reselect one cycle after release, after a write then after a read
        access(0, 1, 21'h6, 2'd0, 2'b00, 16'h0F0F, lat, wid);
        access(0, 0, 21'h7, 2'd0, 2'b00, 16'h0000, lat, wid);
        chk(lat == 8, "R5", "latency after write", lat, 8);
        access(0, 0, 21'h8, 2'd0, 2'b00, 16'h0000, lat, wid);
        chk(lat == 5, "R5", "latency after read", lat, 5);
        repeat (6) @(negedge clk);

        // R7: second select during a page access
        @(negedge clk);
        wr_n = 1'b0; wdata = 16'h2222; be_n = 2'b00; cs_p_n = 1'b0;
        repeat (10) @(negedge clk);
        cs_m_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(confl == 1'b1, "R7", "conflict mid access", confl, 1);
        cs_p_n = 1'b1; cs_m_n = 1'b1; wr_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(confl == 1'b0, "R7", "conflict cleared", confl, 0);
        // R7: both selects from idle start nothing
        cs_p_n = 1'b0; cs_m_n = 1'b0;
        wid = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rdy_oe) wid++;
        end
        chk(wid == 0, "R7", "no access on double select", wid, 0);
        cs_p_n = 1'b1; cs_m_n = 1'b1;
        repeat (6) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule